// File: doc/BRIEF.md
# Multiplexer Fault Latch and Alert Controller

This block tracks fault conditions for a two-channel I2C bus multiplexer and drives the shared, active-low alert line towards the upstream host. It watches a live stuck-low timeout flag, a connection-fault flag, and, for each downstream channel, an active-low alert input and a connected flag. Faults are captured on rising edges into latches. The latches feed two pathways. The first is a dedicated timeout pathway. The second is a grouped pathway, which combines the connection fault with alerts raised on channels that are not connected. An alert on a channel that is connected bypasses the latches entirely, so the host can talk directly to the device that raised it.

The surrounding I2C slave logic provides three one-cycle event pulses: an alert-response broadcast, an access to this device's address, and a write to status register 0. Either of the first two acknowledges every pathway that is latched at that moment, and the alert line is released. A new rising edge of a fault in the grouped pathway re-arms the alert. A write of any data byte to status register 0 clears every latch. The host reads the status word to learn which fault is present.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset, `alert_pull_o` is 0 and every bit of `status_o` that is not a live input copy is 0. Status layout for NUM_CH=2: bit0 is the live timeout, bit1 is the latched timeout, bit2 is the latched connection fault, bits 3+c are the latched fault of channel c, and bits 5+c are the live (synchronized, active-high) alert of channel c.
- R2: A rising edge on `tmo_live_i` sets the latched timeout bit on the next clock. `alert_pull_o` goes high in the same cycle. Bit0 always mirrors `tmo_live_i`.
- R3: When a channel's synchronized alert becomes active while its `ch_conn_i` bit is 0, that channel's latched bit is set one clock later and the grouped pathway asserts `alert_pull_o`. A rising `conn_fault_i` sets bit2 and feeds the same pathway.
- R4: While the latched timeout bit is set, a further timeout rising edge leaves `alert_pull_o` released if the pathway was acknowledged.
- R5: A synchronized channel alert on a connected channel drives `alert_pull_o` high directly, sets no latch, and cannot be acknowledged.
- R6: A pulse on `ara_evt_i` or `addr_evt_i` releases `alert_pull_o` from the next clock for all pathways latched at that time. The status bits are unchanged.
- R7: After release, the alert re-asserts on a rising edge of a different grouped fault, or on a fault that recurs after a clear.
- R8: A pulse on `reg0_wr_i` clears all latched bits and acknowledge state on the next clock.
- R9: When `reg0_wr_i` arrives in the same cycle as a rising fault edge, the clear wins and the latch stays 0.
- R10: Channel alert inputs pass through SYNC_STAGES flip-flops. With the default value of 2, the live bit appears after two clocks and the latched bit after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_live_i | input | 1 | Live stuck-low timeout condition |
| ch_alert_n_i | input | NUM_CH | Per-channel alert inputs, active low, asynchronous |
| ch_conn_i | input | NUM_CH | Channel is connected to the upstream bus |
| conn_fault_i | input | 1 | Downstream connection fault flag |
| ara_evt_i | input | 1 | One-cycle pulse: alert response answered by this device |
| addr_evt_i | input | 1 | One-cycle pulse: this device was addressed |
| reg0_wr_i | input | 1 | One-cycle pulse: data byte written to status register 0 |
| alert_pull_o | output | 1 | 1 pulls the alert line low |
| status_o | output | 3+2*NUM_CH | Status register 0 contents |

## Verification
The bench builds the block with NUM_CH=2 and SYNC_STAGES=2. With two channels, one channel can be connected while the other is not, so the pass-through path and the latched path are both exercised in one run. The two-stage synchronizer makes the exact latency of the live bit and of the latch bit observable cycle by cycle. The bench also exercises acknowledge, re-arm, clear and the same-cycle clear-versus-set case across both pathways.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;

    // Latch plus acknowledge state of one alert pathway.
    typedef struct packed {
        logic lat;
        logic ack;
    } path_t;

    localparam int unsigned ST_TMO_LIVE = 0;
    localparam int unsigned ST_TMO_LAT  = 1;
    localparam int unsigned ST_CONN_LAT = 2;
    localparam int unsigned ST_CH_BASE  = 3;

    function automatic int unsigned status_width(input int unsigned n_ch);
        return ST_CH_BASE + 2 * n_ch;
    endfunction

    // A pathway pulls the alert line while latched and not acknowledged.
    function automatic logic path_active(input path_t p);
        return p.lat & ~p.ack;
    endfunction

endpackage

// File: rtl/fa_sync.sv
module fa_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fa_edge_latch.sv
module fa_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic clr,
    output logic lat,
    output logic rise
);
    logic prev;

    assign rise = cond & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            lat  <= 1'b0;
        end else begin
            prev <= cond;
            if (clr)       lat <= 1'b0;
            else if (rise) lat <= 1'b1;
        end
    end
endmodule

// File: rtl/fa_ack.sv
module fa_ack
    import fault_alert_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lat,
    input  logic  rearm,
    input  logic  evt,
    input  logic  clr,
    output path_t path
);
    logic ack;

    always_ff @(posedge clk) begin
        if (rst)        ack <= 1'b0;
        else if (clr)   ack <= 1'b0;
        else if (rearm) ack <= 1'b0;
        else if (evt)   ack <= lat;
    end

    assign path.lat = lat;
    assign path.ack = ack;
endmodule

// File: rtl/fault_alert_ctrl.sv
module fault_alert_ctrl
    import fault_alert_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tmo_live_i,
    input  logic [NUM_CH-1:0]        ch_alert_n_i,
    input  logic [NUM_CH-1:0]        ch_conn_i,
    input  logic                     conn_fault_i,
    input  logic                     ara_evt_i,
    input  logic                     addr_evt_i,
    input  logic                     reg0_wr_i,
    output logic                     alert_pull_o,
    output logic [3+2*NUM_CH-1:0]    status_o
);
    localparam int unsigned STAT_W = status_width(NUM_CH);

    logic [NUM_CH-1:0] ch_live;
    logic [NUM_CH-1:0] ch_qual;
    logic [NUM_CH-1:0] ch_lat;
    logic [NUM_CH-1:0] ch_rise;
    logic              tmo_lat, tmo_rise;
    logic              conn_lat, conn_rise;
    logic              ack_evt;
    logic              grp_rearm, grp_lat;
    logic              passthru;
    path_t             tmo_path, grp_path;

    assign ack_evt = ara_evt_i | addr_evt_i;

    fa_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (~ch_alert_n_i),
        .q   (ch_live)
    );

    assign ch_qual = ch_live & ~ch_conn_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fa_edge_latch u_lat (
            .clk  (clk),
            .rst  (rst),
            .cond (ch_qual[c]),
            .clr  (reg0_wr_i),
            .lat  (ch_lat[c]),
            .rise (ch_rise[c])
        );
    end

    fa_edge_latch u_conn (
        .clk  (clk),
        .rst  (rst),
        .cond (conn_fault_i),
        .clr  (reg0_wr_i),
        .lat  (conn_lat),
        .rise (conn_rise)
    );

    fa_edge_latch u_tmo (
        .clk  (clk),
        .rst  (rst),
        .cond (tmo_live_i),
        .clr  (reg0_wr_i),
        .lat  (tmo_lat),
        .rise (tmo_rise)
    );

    // Timeout re-arms only from the cleared state.
    fa_ack u_tmo_ack (
        .clk   (clk),
        .rst   (rst),
        .lat   (tmo_lat),
        .rearm (tmo_rise & ~tmo_lat),
        .evt   (ack_evt),
        .clr   (reg0_wr_i),
        .path  (tmo_path)
    );

    assign grp_lat   = conn_lat | (|ch_lat);
    assign grp_rearm = conn_rise | (|ch_rise);

    fa_ack u_grp_ack (
        .clk   (clk),
        .rst   (rst),
        .lat   (grp_lat),
        .rearm (grp_rearm),
        .evt   (ack_evt),
        .clr   (reg0_wr_i),
        .path  (grp_path)
    );

    assign passthru     = |(ch_live & ch_conn_i);
    assign alert_pull_o = passthru | path_active(tmo_path) | path_active(grp_path);

    always_comb begin
        status_o                               = '0;
        status_o[ST_TMO_LIVE]                  = tmo_live_i;
        status_o[ST_TMO_LAT]                   = tmo_lat;
        status_o[ST_CONN_LAT]                  = conn_lat;
        status_o[ST_CH_BASE +: NUM_CH]         = ch_lat;
        status_o[ST_CH_BASE + NUM_CH +: NUM_CH] = ch_live;
    end

    logic unused_ok;
    assign unused_ok = (STAT_W == $bits(status_o));
endmodule

// File: rtl/fault_alert_ctrl_chk.sv
module fault_alert_ctrl_chk #(
    parameter int unsigned NUM_CH = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tmo_live_i,
    input logic [NUM_CH-1:0]     ch_conn_i,
    input logic                  reg0_wr_i,
    input logic                  alert_pull_o,
    input logic [3+2*NUM_CH-1:0] status_o
);
    localparam int unsigned LAT_LO = 1;
    localparam int unsigned LAT_N  = 2 + NUM_CH;

    logic [NUM_CH-1:0] live;
    assign live = status_o[3+NUM_CH +: NUM_CH];

    a_r2_tmo_set: assert property (@(posedge clk) disable iff (rst)
        (tmo_live_i && !$past(tmo_live_i) && !reg0_wr_i) |=> status_o[1]);

    a_r4_tmo_hold: assert property (@(posedge clk) disable iff (rst)
        (status_o[1] && !reg0_wr_i) |=> status_o[1]);

    a_r5_passthru: assert property (@(posedge clk) disable iff (rst)
        ((live & ch_conn_i) != '0) |-> alert_pull_o);

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        reg0_wr_i |=> (status_o[LAT_LO +: LAT_N] == '0));

    a_r6_alert_source: assert property (@(posedge clk) disable iff (rst)
        alert_pull_o |-> ((status_o[LAT_LO +: LAT_N] != '0) || ((live & ch_conn_i) != '0)));
endmodule

bind fault_alert_ctrl fault_alert_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tmo_live_i   (tmo_live_i),
    .ch_conn_i    (ch_conn_i),
    .reg0_wr_i    (reg0_wr_i),
    .alert_pull_o (alert_pull_o),
    .status_o     (status_o)
);

// File: tb/test_fault_alert_ctrl.sv
module test_fault_alert_ctrl;
    localparam int NUM_CH = 2;
    localparam int SW     = 3 + 2 * NUM_CH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tmo = 1'b0;
    logic [NUM_CH-1:0] alert_n = '1;
    logic [NUM_CH-1:0] conn = '0;
    logic cfault = 1'b0, ara = 1'b0, addr = 1'b0, wr0 = 1'b0;
    logic pull;
    logic [SW-1:0] status;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string          req;
        logic           alert;
        logic [SW-1:0]  st;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    fault_alert_ctrl #(.NUM_CH(NUM_CH), .SYNC_STAGES(2)) i_fault_alert_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tmo_live_i   (tmo),
        .ch_alert_n_i (alert_n),
        .ch_conn_i    (conn),
        .conn_fault_i (cfault),
        .ara_evt_i    (ara),
        .addr_evt_i   (addr),
        .reg0_wr_i    (wr0),
        .alert_pull_o (pull),
        .status_o     (status)
    );

    // Driver side: wait n clock edges, then queue the expectation.
    task automatic expect_after(input int n, input string req,
                                input logic a, input logic [SW-1:0] st);
        repeat (n) @(posedge clk);
        #1;
        q.push_back('{req: req, alert: a, st: st});
    endtask

    // Pulse one event for a single cycle: 0=ara 1=addr 2=reg0 write.
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ara = 1'b1;
            1: addr = 1'b1;
            default: wr0 = 1'b1;
        endcase
        @(negedge clk);
        ara = 1'b0; addr = 1'b0; wr0 = 1'b0;
    endtask

    // Monitor: pops and compares after each edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (pull !== e.alert || status !== e.st) begin
                    failures++;
                    $display("FAIL %s: alert=%b status=%h expected alert=%b status=%h",
                             e.req, pull, status, e.alert, e.st);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        expect_after(1, "R1 reset state", 1'b0, 7'h00);

        // R2: timeout latched and alert raised
        @(negedge clk) tmo = 1'b1;
        expect_after(1, "R2 timeout latch", 1'b1, 7'h03);
        // R6: alert response releases
        pulse(0);
        expect_after(0, "R6 release by alert response", 1'b0, 7'h03);
        // R4: second timeout edge while latched is ignored
        @(negedge clk) tmo = 1'b0;
        @(negedge clk) tmo = 1'b1;
        expect_after(2, "R4 second timeout ignored", 1'b0, 7'h03);
        // R8: register 0 write clears latches
        pulse(2);
        expect_after(0, "R8 clear by reg0 write", 1'b0, 7'h01);
        @(negedge clk) tmo = 1'b0;
        @(negedge clk) tmo = 1'b1;
        expect_after(1, "R7 timeout recurs after clear", 1'b1, 7'h03);
        pulse(2);
        @(negedge clk) tmo = 1'b0;
        expect_after(1, "R8 cleared, timeout gone", 1'b0, 7'h00);

        // R10 + R3: disconnected channel 0 alert, latency check
        @(negedge clk) alert_n[0] = 1'b0;
        expect_after(1, "R10 one stage only", 1'b0, 7'h00);
        expect_after(1, "R10 live after two stages", 1'b0, 7'h20);
        expect_after(1, "R3 channel latch after three", 1'b1, 7'h28);
        // R6: addressed releases
        pulse(1);
        expect_after(0, "R6 release by addressing", 1'b0, 7'h28);
        // R7: different grouped fault re-alerts
        @(negedge clk) cfault = 1'b1;
        expect_after(1, "R7 different fault re-alerts R3", 1'b1, 7'h2C);
        pulse(0);
        expect_after(0, "R6 release again", 1'b0, 7'h2C);
        @(negedge clk) begin alert_n[0] = 1'b1; cfault = 1'b0; end
        expect_after(3, "R3 latches hold after faults go", 1'b0, 7'h0C);
        pulse(2);
        expect_after(0, "R8 group cleared", 1'b0, 7'h00);

        // R5: connected channel 1 passes straight through
        @(negedge clk) begin conn[1] = 1'b1; alert_n[1] = 1'b0; end
        expect_after(2, "R5 pass-through", 1'b1, 7'h40);
        pulse(0);
        expect_after(0, "R5 pass-through not acknowledged", 1'b1, 7'h40);
        @(negedge clk) alert_n[1] = 1'b1;
        expect_after(2, "R5 pass-through ends", 1'b0, 7'h00);
        @(negedge clk) conn[1] = 1'b0;

        // R9: clear in the same cycle as a timeout rising edge
        @(negedge clk) begin tmo = 1'b1; wr0 = 1'b1; end
        @(negedge clk) wr0 = 1'b0;
        expect_after(1, "R9 clear beats set", 1'b0, 7'h01);
        @(negedge clk) tmo = 1'b0;

        repeat (3) @(posedge clk);
        #5;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule